// File: doc/BRIEF.md
# Dual Interval Timer with Status Register

This block gives a host two independent 8-bit interval timers behind a two-step write interface. The host first presents a register index with the address strobe. Each later data strobe writes its byte into the register that the index names. The index stays latched, so repeated data strobes land in the same register. Each timer has a preload register and shares one control register with the other timer. The control register starts and masks each timer, and one command bit clears the overflow flags.

A running timer loads its preload value into an up-counter. It advances the counter by one on every step of its own prescaler. When it steps past 0xFF, it raises a sticky overflow flag and reloads the counter from the current preload value. It keeps running until the host stops or masks it. Timer 1 steps every `BASE_DIV` clocks, which is 80 µs at the default values. Timer 2 steps `T2_RATIO` times slower, which is 320 µs. A host that wants N steps writes 256−N as the preload value.

A status byte is always driven. It holds a combined interrupt bit, the two overflow flags and a fixed identification code. The `irq` output follows the combined bit.

Top module: `dual_timer_top`

## Requirements
- R1: After reset, `status` reads 0x06, which is bits 7..5 at zero plus the 5-bit identification code 0b00110 in bits 4..0, and `irq` is 0.
- R2: If preload index 0x02 holds p and a control write (index 0x04) sets bit 0 to start timer 1 while bit 6 (mask timer 1) is 0, then status bit 6 rises at the clock edge exactly 1 + (256−p)·BASE_DIV edges after the write edge, and not before it.
- R3: Timer 2 behaves like timer 1, with preload index 0x03, start bit 1, mask bit 5 and flag in status bit 6→5. Its step is BASE_DIV·T2_RATIO clocks, so its flag rises 1 + (256−p)·BASE_DIV·T2_RATIO edges after the start write.
- R4: Status bit 7 equals the OR of status bits 6 and 5, and `irq` always equals status bit 7.
- R5: A timer that stays started and unmasked reloads from its preload value on each overflow. A flag that has been cleared rises again exactly one period later.
- R6: While a timer's mask bit is 1, that timer does not count and its flag never rises, even if its start bit is 1.
- R7: Writing a control byte with a timer's start bit at 0 halts that timer. A later start reloads the counter from the preload value and measures the full period from the new start write.
- R8: A control write with bit 7 set clears both flags at that write edge. All other bits of that byte are ignored, so start and mask settings are unchanged and running timers keep their schedule. Without such a write, a set flag stays set.
- R9: A data strobe writes the register named by the last latched index. Indexes other than 0x02, 0x03 and 0x04 change nothing. A preload write to a running timer first takes effect at its next reload.
- R10: If an overflow and a bit-7 control write fall on the same clock edge, the flag is left set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_we | input | 1 | Address strobe: latches `wdata` as the register index |
| data_we | input | 1 | Data strobe: writes `wdata` into the indexed register |
| wdata | input | 8 | Index or data byte from the host |
| status | output | 8 | {interrupt, timer 1 flag, timer 2 flag, identification code} |
| irq | output | 1 | Interrupt request, high while any flag is set |

## Verification
The assertions assume that the strobes are clean single-clock pulses sampled at the rising edge. They also assume that a flag-clearing command is the only source that lowers a flag, and that the host does not rely on the order of an address strobe and a data strobe issued in the same cycle. The stimulus never raises both strobes together: it drives each bus operation on its own falling edge. It stops and then clears the timers before every new scenario, so that no clear lands on an overflow edge by accident. The one exception is the deliberate same-edge case. Random preload values are kept close to 0xFF so that each period stays short enough to be checked cycle by cycle.

// File: rtl/dual_timer_pkg.sv
`timescale 1ns/1ps
package dual_timer_pkg;

    localparam int NUM_TMR  = 2;
    localparam int CNT_W    = 8;

    // register indexes seen by the host
    localparam logic [7:0] IDX_PRE_T1 = 8'h02;
    localparam logic [7:0] IDX_PRE_T2 = 8'h03;
    localparam logic [7:0] IDX_CTRL   = 8'h04;

    // control byte bit positions
    localparam int CB_CLR     = 7;
    localparam int CB_MASK_T1 = 6;
    localparam int CB_MASK_T2 = 5;
    localparam int CB_GO_T2   = 1;
    localparam int CB_GO_T1   = 0;

    typedef struct packed {
        logic                 clr;
        logic [NUM_TMR-1:0]   mask;
        logic [NUM_TMR-1:0]   go;
    } ctrl_t;

    function automatic ctrl_t ctrl_decode(input logic [7:0] b);
        ctrl_t c;
        c.clr     = b[CB_CLR];
        c.mask[0] = b[CB_MASK_T1];
        c.mask[1] = b[CB_MASK_T2];
        c.go[0]   = b[CB_GO_T1];
        c.go[1]   = b[CB_GO_T2];
        return c;
    endfunction

    function automatic logic idx_is_valid(input logic [7:0] idx);
        return (idx == IDX_PRE_T1) || (idx == IDX_PRE_T2) || (idx == IDX_CTRL);
    endfunction

endpackage

// File: rtl/dual_timer_regs.sv
`timescale 1ns/1ps
module dual_timer_regs
    import dual_timer_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            addr_we,
    input  logic                            data_we,
    input  logic [7:0]                      wdata,
    output logic [7:0]                      idx_q,
    output logic [NUM_TMR-1:0][CNT_W-1:0]   preload,
    output logic [NUM_TMR-1:0]              run,
    output logic                            clr_flags
);

    ctrl_t               wr_ctrl;
    logic [NUM_TMR-1:0]  go_q;
    logic [NUM_TMR-1:0]  mask_q;
    logic                ctrl_hit;

    assign wr_ctrl   = ctrl_decode(wdata);
    assign ctrl_hit  = data_we && (idx_q == IDX_CTRL);
    assign clr_flags = ctrl_hit && wr_ctrl.clr;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (addr_we) begin
            idx_q <= wdata;
        end
    end

    // one preload register per timer, index = IDX_PRE_T1 + channel
    for (genvar i = 0; i < NUM_TMR; i++) begin : g_pre
        localparam logic [7:0] MY_IDX = IDX_PRE_T1 + 8'(i);
        always_ff @(posedge clk) begin
            if (rst) begin
                preload[i] <= '0;
            end else if (data_we && (idx_q == MY_IDX)) begin
                preload[i] <= wdata;
            end
        end
    end

    // a clear command leaves start and mask untouched
    always_ff @(posedge clk) begin
        if (rst) begin
            go_q   <= '0;
            mask_q <= '0;
        end else if (ctrl_hit && !wr_ctrl.clr) begin
            go_q   <= wr_ctrl.go;
            mask_q <= wr_ctrl.mask;
        end
    end

    assign run = go_q & ~mask_q;

endmodule

// File: rtl/dual_timer_chan.sv
`timescale 1ns/1ps
module dual_timer_chan
    import dual_timer_pkg::*;
#(
    parameter int PERIOD = 20000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [CNT_W-1:0]  preload,
    input  logic              clr,
    output logic              flag
);

    localparam int PRES_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
    localparam logic [PRES_W-1:0] PRES_LAST = PRES_W'(PERIOD - 1);

    logic              run_q;
    logic [PRES_W-1:0] pres;
    logic [CNT_W-1:0]  cnt;
    logic              step;
    logic              ovf;

    assign step = run && run_q && (pres == PRES_LAST);
    assign ovf  = step && (cnt == {CNT_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= 1'b0;
            pres  <= '0;
            cnt   <= '0;
        end else begin
            run_q <= run;
            if (run && !run_q) begin
                cnt  <= preload;
                pres <= '0;
            end else if (run) begin
                if (step) begin
                    pres <= '0;
                    cnt  <= ovf ? preload : cnt + 1'b1;
                end else begin
                    pres <= pres + 1'b1;
                end
            end
        end
    end

    // overflow beats a clear on the same edge
    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (ovf) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/dual_timer_top.sv
`timescale 1ns/1ps
module dual_timer_top
    import dual_timer_pkg::*;
#(
    parameter int         BASE_DIV = 20000,
    parameter int         T2_RATIO = 4,
    parameter logic [4:0] CHIP_ID  = 5'b00110
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        addr_we,
    input  logic        data_we,
    input  logic [7:0]  wdata,
    output logic [7:0]  status,
    output logic        irq
);

    logic [7:0]                      idx_q;
    logic [NUM_TMR-1:0][CNT_W-1:0]   preload;
    logic [NUM_TMR-1:0]              run;
    logic                            clr_flags;
    logic [NUM_TMR-1:0]              flag;

    dual_timer_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .addr_we   (addr_we),
        .data_we   (data_we),
        .wdata     (wdata),
        .idx_q     (idx_q),
        .preload   (preload),
        .run       (run),
        .clr_flags (clr_flags)
    );

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_chan
        localparam int PER = (i == 0) ? BASE_DIV : BASE_DIV * T2_RATIO;
        dual_timer_chan #(.PERIOD(PER)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .run     (run[i]),
            .preload (preload[i]),
            .clr     (clr_flags),
            .flag    (flag[i])
        );
    end

    assign irq    = |flag;
    assign status = {irq, flag[0], flag[1], CHIP_ID};

endmodule

// File: rtl/dual_timer_chk.sv
`timescale 1ns/1ps
module dual_timer_chk
    import dual_timer_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            data_we,
    input  logic [7:0]                      wdata,
    input  logic [7:0]                      idx_q,
    input  logic [NUM_TMR-1:0][CNT_W-1:0]   preload,
    input  logic [NUM_TMR-1:0]              run,
    input  logic [NUM_TMR-1:0]              flag,
    input  logic [7:0]                      status,
    input  logic                            irq
);

    logic clr_cmd;
    assign clr_cmd = data_we && (idx_q == IDX_CTRL) && wdata[CB_CLR];

    // R4: interrupt output and status summary bit agree with the flags
    a_r4_irq_summary: assert property (@(posedge clk) disable iff (rst)
        (irq == status[7]) && (status[7] == (status[6] | status[5])));

    // R6: a flag can only rise after its timer was running
    a_r6_t1_rise_needs_run: assert property (@(posedge clk) disable iff (rst)
        $rose(flag[0]) |-> $past(run[0]));
    a_r6_t2_rise_needs_run: assert property (@(posedge clk) disable iff (rst)
        $rose(flag[1]) |-> $past(run[1]));

    // R8: clear with both timers idle leaves all flag bits at zero
    a_r8_clear_idle: assert property (@(posedge clk) disable iff (rst)
        (clr_cmd && !run[0] && !run[1]) |=> (status[7:5] == 3'b000));

    // R8: flags are sticky without a clear command
    a_r8_t1_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag[0] && !clr_cmd) |=> flag[0]);
    a_r8_t2_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag[1] && !clr_cmd) |=> flag[1]);

    // R8: a clear command does not touch run state
    a_r8_clear_keeps_run: assert property (@(posedge clk) disable iff (rst)
        clr_cmd |=> $stable(run));

    // R9: data to an unknown index changes no register
    a_r9_bad_index: assert property (@(posedge clk) disable iff (rst)
        (data_we && !idx_is_valid(idx_q)) |=> ($stable(preload) && $stable(run)));

endmodule

bind dual_timer_top dual_timer_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .data_we (data_we),
    .wdata   (wdata),
    .idx_q   (idx_q),
    .preload (preload),
    .run     (run),
    .flag    (flag),
    .status  (status),
    .irq     (irq)
);

// File: tb/dual_timer_top_bench.sv
`timescale 1ns/1ps
module dual_timer_top_bench;

    localparam int BASE  = 8;
    localparam int RATIO = 4;
    localparam int P1    = BASE;
    localparam int P2    = BASE * RATIO;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       addr_we = 1'b0;
    logic       data_we = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] status;
    logic       irq;

    int unsigned cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    dual_timer_top #(.BASE_DIV(BASE), .T2_RATIO(RATIO)) u_dual_timer_top (
        .clk     (clk),
        .rst     (rst),
        .addr_we (addr_we),
        .data_we (data_we),
        .wdata   (wdata),
        .status  (status),
        .irq     (irq)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int unsigned ovf_delay(input int ch, input logic [7:0] p);
        return 1 + (256 - int'(p)) * ((ch == 0) ? P1 : P2);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        addr_we = 1'b1; wdata = a;
        @(negedge clk);
        addr_we = 1'b0; data_we = 1'b1; wdata = d;
        @(negedge clk);
        data_we = 1'b0; wdata = 8'h00;
    endtask

    task automatic data_only(input logic [7:0] d);
        data_we = 1'b1; wdata = d;
        @(negedge clk);
        data_we = 1'b0; wdata = 8'h00;
    endtask

    task automatic wait_cyc(input int unsigned target);
        while (cyc < target) @(negedge clk);
    endtask

    // flag at status bit b is low just before edge e and high just after
    task automatic expect_edge(input int b, input int unsigned e, input string tag);
        wait_cyc(e - 1);
        chk({tag, " before"}, 32'(status[b]), 32'd0);
        @(negedge clk);
        chk({tag, " at"}, 32'(status[b]), 32'd1);
    endtask

    task automatic quiesce();
        wr(8'h04, 8'h00);
        wr(8'h04, 8'h80);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned t0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 status", 32'(status), 32'h06);
        chk("R1 irq", 32'(irq), 32'd0);

        // R2 shortest period, timer 2 masked
        wr(8'h02, 8'hFF);
        wr(8'h04, 8'h21);
        t0 = cyc;
        expect_edge(6, t0 + ovf_delay(0, 8'hFF), "R2 p=FF");
        chk("R4 bits 7..5", 32'(status[7:5]), 32'b110);
        chk("R4 irq", 32'(irq), 32'd1);
        quiesce();
        chk("R8 cleared", 32'(status[7:5]), 32'b000);
        chk("R8 irq low", 32'(irq), 32'd0);

        // R3 timer 2 period
        wr(8'h03, 8'hF0);
        wr(8'h04, 8'h02);
        t0 = cyc;
        expect_edge(5, t0 + ovf_delay(1, 8'hF0), "R3 p=F0");
        chk("R4 t2 summary", 32'(status[7:5]), 32'b101);
        quiesce();

        // R2 long period, then R8 clear while running and R5 reload
        wr(8'h02, 8'h80);
        wr(8'h04, 8'h01);
        t0 = cyc;
        expect_edge(6, t0 + ovf_delay(0, 8'h80), "R2 p=80");
        wr(8'h04, 8'hC0);
        chk("R8 clear running", 32'(status[7:5]), 32'b000);
        expect_edge(6, t0 + ovf_delay(0, 8'h80) + 128 * P1, "R5 R8 reload period");
        quiesce();

        // R7 stop then restart measures from the restart
        wr(8'h02, 8'hF0);
        wr(8'h04, 8'h01);
        repeat (60) @(negedge clk);
        wr(8'h04, 8'h00);
        repeat (200) @(negedge clk);
        chk("R7 halted", 32'(status[6]), 32'd0);
        wr(8'h04, 8'h01);
        t0 = cyc;
        expect_edge(6, t0 + ovf_delay(0, 8'hF0), "R7 restart");
        quiesce();

        // R6 masks block both timers
        wr(8'h02, 8'hFF);
        wr(8'h03, 8'hFF);
        wr(8'h04, 8'h63);
        repeat (300) @(negedge clk);
        chk("R6 masked", 32'(status[7:5]), 32'b000);
        wr(8'h04, 8'h03);
        t0 = cyc;
        expect_edge(6, t0 + ovf_delay(0, 8'hFF), "R6 unmask t1");
        expect_edge(5, t0 + ovf_delay(1, 8'hFF), "R6 unmask t2");
        quiesce();

        // R9 preload change while running waits for the reload
        wr(8'h02, 8'hFC);
        wr(8'h04, 8'h01);
        t0 = cyc;
        wr(8'h02, 8'hF8);
        expect_edge(6, t0 + ovf_delay(0, 8'hFC), "R9 old preload");
        wr(8'h04, 8'h80);
        expect_edge(6, t0 + ovf_delay(0, 8'hFC) + 8 * P1, "R9 new preload");
        wr(8'h07, 8'h80);
        chk("R9 bad index no clear", 32'(status[6]), 32'd1);
        quiesce();
        wr(8'h01, 8'h01);
        repeat (100) @(negedge clk);
        chk("R9 bad index no start", 32'(status[7:5]), 32'b000);

        // R9 index stays latched across data strobes
        wr(8'h04, 8'h00);
        data_only(8'h01);
        t0 = cyc;
        expect_edge(6, t0 + ovf_delay(0, 8'hF8), "R9 index held");

        // R10 clear on the overflow edge
        data_only(8'h80);
        chk("R10 pre clear", 32'(status[6]), 32'd0);
        wait_cyc(t0 + ovf_delay(0, 8'hF8) + 8 * P1 - 1);
        data_only(8'h80);
        chk("R10 same edge keeps flag", 32'(status[6]), 32'd1);
        quiesce();

        // random preload and channel selection
        for (int it = 0; it < 12; it++) begin
            int ch;
            logic [7:0] p;
            logic [7:0] c;
            logic [31:0] r;
            r  = $urandom;
            ch = int'(r[0]);
            p  = (ch == 1) ? {4'hF, r[7:4]} : {2'b11, r[9:4]};
            c  = (ch == 1) ? 8'h02 : 8'h01;
            if (r[12]) c = c | ((ch == 1) ? 8'h40 : 8'h20);
            wr(8'h02 + 8'(ch), p);
            wr(8'h04, c);
            t0 = cyc;
            expect_edge((ch == 1) ? 5 : 6, t0 + ovf_delay(ch, p), (ch == 1) ? "R3 random" : "R2 random");
            chk("R4 random irq", 32'({irq, status[7]}), 32'b11);
            quiesce();
            chk("R8 random clear", 32'(status[7:5]), 32'b000);
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule